// File: doc/BRIEF.md
# Time-Multiplexed Polyphase FIR Filterbank

This block runs one complex FIR filter per channel for a set of channels whose samples share a single stream. The channels take turns: the first sample after reset belongs to channel 0, the next to channel 1, and so on. After the last channel the order wraps back to channel 0. A single multiply-accumulate engine does all of the arithmetic. Each channel keeps its own tap set and its own sample history in on-chip arrays. The engine spends one clock per tap on each incoming sample.

Input samples are complex, with signed 16-bit real and imaginary halves. Coefficients are real and signed 32-bit. Outputs are complex, with signed 32-bit halves. The full-precision sum is rounded half-up, shifted right by 31 bits and then clamped to the output range. Each accepted input produces exactly one output, tagged with its channel index, and outputs leave in arrival order. Coefficients are written one at a time through a separate port, addressed by channel and tap, while the engine is idle. A typical use is the filtering front end of a channelizer, with the transform stage placed after it.

Top module: `tdmfb_top`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0, every channel's history holds zeros, and the next accepted sample is assigned to channel 0.
- R2: Accepted samples are assigned to channels 0, 1, …, NCH-1 cyclically. Each one yields exactly one output whose `out_ch` equals that channel.
- R3: For a sample accepted as the n-th sample of channel c, the accumulator is the sum over k = 0..TAPS-1 of coef[c][k] · x_c[n-k]. Tap 0 multiplies the newest sample, and samples from before reset count as 0. Channels do not affect each other's history.
- R4: The output is (acc + 2^(SHIFT-1)) arithmetically shifted right by SHIFT, with SHIFT = 31 by default. This is round-half-up, so +0.5 rounds to 1 and -0.5 rounds to 0.
- R5: A shifted value outside the range [-2^(OUT_W-1), 2^(OUT_W-1)-1] is clamped to the nearer end of that range and never wrapped.
- R6: The real and imaginary halves are filtered independently with the same real coefficients.
- R7: With `cfg_we` high in a cycle where `in_ready` is 1, the value on `cfg_coef` becomes coef[`cfg_ch`][`cfg_tap`]. A write presented while a sample is being processed or an output is pending is discarded.
- R8: `in_ready` is high only while no sample is in flight. `out_valid`, `out_ch`, `out_re` and `out_im` hold steady until `out_ready` is seen, and `in_ready` returns in the cycle after the output handshake.
- R9: `out_valid` goes high exactly TAPS clock edges after the edge on which the input handshake occurred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_ch | input | CH_W | Channel index of the coefficient write |
| cfg_tap | input | TAP_W | Tap index of the coefficient write (0 = newest sample) |
| cfg_coef | input | COEF_W | Signed coefficient value |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can accept a sample |
| in_re | input | SMP_W | Input sample, real part |
| in_im | input | SMP_W | Input sample, imaginary part |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream accepts the output |
| out_ch | output | CH_W | Channel the output belongs to |
| out_re | output | OUT_W | Output, real part |
| out_im | output | OUT_W | Output, imaginary part |

## Verification
With a 31-bit shift and 36 taps of 16×32-bit products, the default instance can never reach its clamp limits. The bench therefore drives a second instance with an 8-bit shift from the same stimulus. One channel is loaded with all-minimum coefficients and fed full-scale samples of alternating sign, which pushes that instance into both clamp limits. The ignored coefficient write is another case that is hard to reach from the ports. It is produced by strobing the write port one cycle into a channel's accumulation, and the effect shows up one frame later in that channel's result. The rounding tie is reached by reloading two channels with a single tap of 2^30 and feeding ±1 and ±3.

// File: rtl/tdmfb_pkg.sv
`timescale 1ns/1ps
package tdmfb_pkg;
  localparam int ACC_W = 64;

  typedef enum logic [1:0] {ST_IDLE, ST_MAC, ST_OUT} fb_state_e;

  // Round half-up at bit (shift-1), arithmetic shift, clamp to out_w signed.
  function automatic logic signed [ACC_W-1:0] round_shift_sat(
    input logic signed [ACC_W-1:0] acc,
    input int shift,
    input int out_w);
    logic signed [ACC_W-1:0] bias;
    logic signed [ACC_W-1:0] shifted;
    logic signed [ACC_W-1:0] hi;
    logic signed [ACC_W-1:0] lo;
    bias    = 64'sd1 <<< (shift - 1);
    shifted = (acc + bias) >>> shift;
    hi      = (64'sd1 <<< (out_w - 1)) - 64'sd1;
    lo      = -hi - 64'sd1;
    if (shifted > hi)      return hi;
    else if (shifted < lo) return lo;
    else                   return shifted;
  endfunction
endpackage

// File: rtl/tdmfb_coef_ram.sv
`timescale 1ns/1ps
module tdmfb_coef_ram #(
  parameter int NCH    = 16,
  parameter int TAPS   = 36,
  parameter int COEF_W = 32,
  parameter int CH_W   = 4,
  parameter int TAP_W  = 6
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [CH_W-1:0]   wr_ch,
  input  logic [TAP_W-1:0]  wr_tap,
  input  logic [COEF_W-1:0] wr_data,
  input  logic [CH_W-1:0]   rd_ch,
  input  logic [TAP_W-1:0]  rd_tap,
  output logic [COEF_W-1:0] rd_data
);
  logic [COEF_W-1:0] mem [NCH][TAPS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ch][wr_tap] <= wr_data;
  end

  assign rd_data = mem[rd_ch][rd_tap];
endmodule

// File: rtl/tdmfb_hist_ram.sv
`timescale 1ns/1ps
module tdmfb_hist_ram #(
  parameter int NCH   = 16,
  parameter int HD    = 35,
  parameter int SMP_W = 16,
  parameter int CH_W  = 4,
  parameter int AGE_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CH_W-1:0]  wr_ch,
  input  logic [SMP_W-1:0] wr_re,
  input  logic [SMP_W-1:0] wr_im,
  input  logic [CH_W-1:0]  rd_ch,
  input  logic [AGE_W-1:0] rd_age,
  output logic [SMP_W-1:0] rd_re,
  output logic [SMP_W-1:0] rd_im
);
  localparam int SL_W = (HD > 1) ? $clog2(HD) : 1;

  logic [SMP_W-1:0] mem_re [NCH][HD];
  logic [SMP_W-1:0] mem_im [NCH][HD];
  logic [SL_W-1:0]  wp_q   [NCH];
  logic [SL_W-1:0]  rd_slot;

  // Ring per channel: wp points at the oldest entry (next to overwrite).
  always_comb begin
    int s;
    s = int'(wp_q[rd_ch]) - int'(rd_age);
    if (s < 0) s = s + HD;
    rd_slot = SL_W'(s);
  end

  assign rd_re = mem_re[rd_ch][rd_slot];
  assign rd_im = mem_im[rd_ch][rd_slot];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        wp_q[c] <= '0;
        for (int h = 0; h < HD; h++) begin
          mem_re[c][h] <= '0;
          mem_im[c][h] <= '0;
        end
      end
    end else if (wr_en) begin
      mem_re[wr_ch][wp_q[wr_ch]] <= wr_re;
      mem_im[wr_ch][wp_q[wr_ch]] <= wr_im;
      wp_q[wr_ch] <= (wp_q[wr_ch] == SL_W'(HD - 1)) ? '0 : wp_q[wr_ch] + SL_W'(1);
    end
  end

  AST_WP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wp_q[wr_ch]) < HD)); // R3
endmodule

// File: rtl/tdmfb_mac.sv
`timescale 1ns/1ps
module tdmfb_mac #(
  parameter int SMP_W  = 16,
  parameter int COEF_W = 32,
  parameter int ACC_W  = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 en,
  input  logic [2*SMP_W-1:0]   smp_pair,
  input  logic [COEF_W-1:0]    coef,
  output logic [2*ACC_W-1:0]   nxt_pair
);
  localparam int PW = SMP_W + COEF_W;

  for (genvar lane = 0; lane < 2; lane++) begin : g_lane
    logic [SMP_W-1:0]        s;
    logic signed [PW-1:0]    prod;
    logic signed [ACC_W-1:0] prod_ext;
    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W-1:0] nxt;

    assign s        = smp_pair[lane*SMP_W +: SMP_W];
    assign prod     = $signed({{COEF_W{s[SMP_W-1]}}, s}) *
                      $signed({{SMP_W{coef[COEF_W-1]}}, coef});
    assign prod_ext = {{(ACC_W-PW){prod[PW-1]}}, prod};
    assign nxt      = acc_q + prod_ext;
    assign nxt_pair[lane*ACC_W +: ACC_W] = nxt;

    always_ff @(posedge clk) begin
      if (!rst_n || clr) acc_q <= '0;
      else if (en)       acc_q <= nxt;
    end
  end
endmodule

// File: rtl/tdmfb_top.sv
`timescale 1ns/1ps
module tdmfb_top
  import tdmfb_pkg::*;
#(
  parameter int NCH    = 16,
  parameter int TAPS   = 36,
  parameter int SMP_W  = 16,
  parameter int COEF_W = 32,
  parameter int OUT_W  = 32,
  parameter int SHIFT  = 31,
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int TAP_W = $clog2(TAPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CH_W-1:0]   cfg_ch,
  input  logic [TAP_W-1:0]  cfg_tap,
  input  logic [COEF_W-1:0] cfg_coef,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [SMP_W-1:0]  in_re,
  input  logic [SMP_W-1:0]  in_im,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CH_W-1:0]   out_ch,
  output logic [OUT_W-1:0]  out_re,
  output logic [OUT_W-1:0]  out_im
);
  localparam int HD = TAPS - 1;

  fb_state_e         st_q;
  logic [CH_W-1:0]   ch_ptr_q;
  logic [CH_W-1:0]   cur_ch_q;
  logic [TAP_W-1:0]  tap_q;
  logic [SMP_W-1:0]  cur_re_q, cur_im_q;
  logic [OUT_W-1:0]  out_re_q, out_im_q;

  // Named events for the datapath and the assertions.
  logic in_fire, out_fire, mac_on, mac_last, cfg_take;
  assign in_ready  = (st_q == ST_IDLE);
  assign out_valid = (st_q == ST_OUT);
  assign in_fire   = in_valid && in_ready;
  assign out_fire  = out_valid && out_ready;
  assign mac_on    = (st_q == ST_MAC);
  assign mac_last  = mac_on && (tap_q == TAP_W'(TAPS - 1));
  assign cfg_take  = cfg_we && in_ready;

  logic [COEF_W-1:0] coef_rd;
  logic [SMP_W-1:0]  hist_re, hist_im;
  logic [SMP_W-1:0]  mac_re, mac_im;
  logic [2*ACC_W-1:0] nxt_pair;
  logic signed [ACC_W-1:0] rs_re, rs_im;

  tdmfb_coef_ram #(.NCH(NCH), .TAPS(TAPS), .COEF_W(COEF_W), .CH_W(CH_W), .TAP_W(TAP_W)) u_coef (
    .clk(clk), .wr_en(cfg_take), .wr_ch(cfg_ch), .wr_tap(cfg_tap), .wr_data(cfg_coef),
    .rd_ch(cur_ch_q), .rd_tap(tap_q), .rd_data(coef_rd));

  tdmfb_hist_ram #(.NCH(NCH), .HD(HD), .SMP_W(SMP_W), .CH_W(CH_W), .AGE_W(TAP_W)) u_hist (
    .clk(clk), .rst_n(rst_n), .wr_en(mac_last), .wr_ch(cur_ch_q),
    .wr_re(cur_re_q), .wr_im(cur_im_q), .rd_ch(cur_ch_q), .rd_age(tap_q),
    .rd_re(hist_re), .rd_im(hist_im));

  // Tap 0 uses the sample just accepted; older taps come from the ring.
  assign mac_re = (tap_q == '0) ? cur_re_q : hist_re;
  assign mac_im = (tap_q == '0) ? cur_im_q : hist_im;

  tdmfb_mac #(.SMP_W(SMP_W), .COEF_W(COEF_W), .ACC_W(ACC_W)) u_mac (
    .clk(clk), .rst_n(rst_n), .clr(in_fire), .en(mac_on),
    .smp_pair({mac_im, mac_re}), .coef(coef_rd), .nxt_pair(nxt_pair));

  assign rs_re = round_shift_sat($signed(nxt_pair[ACC_W-1:0]), SHIFT, OUT_W);
  assign rs_im = round_shift_sat($signed(nxt_pair[2*ACC_W-1:ACC_W]), SHIFT, OUT_W);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      ch_ptr_q <= '0;
      cur_ch_q <= '0;
      tap_q    <= '0;
      cur_re_q <= '0;
      cur_im_q <= '0;
      out_re_q <= '0;
      out_im_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (in_fire) begin
          cur_re_q <= in_re;
          cur_im_q <= in_im;
          cur_ch_q <= ch_ptr_q;
          ch_ptr_q <= (ch_ptr_q == CH_W'(NCH - 1)) ? '0 : ch_ptr_q + CH_W'(1);
          tap_q    <= '0;
          st_q     <= ST_MAC;
        end
        ST_MAC: begin
          tap_q <= tap_q + TAP_W'(1);
          if (mac_last) begin
            out_re_q <= rs_re[OUT_W-1:0];
            out_im_q <= rs_im[OUT_W-1:0];
            st_q     <= ST_OUT;
          end
        end
        ST_OUT: if (out_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign out_ch = cur_ch_q;
  assign out_re = out_re_q;
  assign out_im = out_im_q;

  // Observation registers used only by the properties below.
  logic [TAP_W:0]  lat_q;
  logic [CH_W-1:0] seen_ch_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_q     <= '0;
      seen_ch_q <= '0;
    end else begin
      if (in_fire)     lat_q <= '0;
      else if (mac_on) lat_q <= lat_q + (TAP_W+1)'(1);
      if (out_fire)
        seen_ch_q <= (seen_ch_q == CH_W'(NCH - 1)) ? '0 : seen_ch_q + CH_W'(1);
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_re) && $stable(out_im) && $stable(out_ch))); // R8
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid)); // R8
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (int'(lat_q) == TAPS)); // R9
  AST_CH_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    out_fire |-> (out_ch == seen_ch_q)); // R2
  AST_TAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    mac_on |-> (int'(tap_q) < TAPS)); // R3
  AST_SAT_FIT: assert property (@(posedge clk) disable iff (!rst_n)
    mac_last |-> ((rs_re == ACC_W'($signed(rs_re[OUT_W-1:0]))) &&
                  (rs_im == ACC_W'($signed(rs_im[OUT_W-1:0]))))); // R5
endmodule

// File: tb/tdmfb_top_bench.sv
`timescale 1ns/1ps
module tdmfb_top_bench;
  localparam int NCH = 16;
  localparam int TAPS = 36;
  localparam int LOW_SHIFT = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_ch;
  logic [5:0]  cfg_tap;
  logic [31:0] cfg_coef;
  logic        in_valid;
  logic [15:0] in_re, in_im;
  logic        out_ready;
  logic        ir_a, ov_a, ir_b, ov_b;
  logic [3:0]  och_a, och_b;
  logic [31:0] ore_a, oim_a, ore_b, oim_b;

  tdmfb_top #(.NCH(NCH), .TAPS(TAPS)) u_tdmfb_top (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_tap(cfg_tap),
    .cfg_coef(cfg_coef), .in_valid(in_valid), .in_ready(ir_a), .in_re(in_re), .in_im(in_im),
    .out_valid(ov_a), .out_ready(out_ready), .out_ch(och_a), .out_re(ore_a), .out_im(oim_a));

  tdmfb_top #(.NCH(NCH), .TAPS(TAPS), .SHIFT(LOW_SHIFT)) u_tdmfb_top_lowshift (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_tap(cfg_tap),
    .cfg_coef(cfg_coef), .in_valid(in_valid), .in_ready(ir_b), .in_re(in_re), .in_im(in_im),
    .out_valid(ov_b), .out_ready(out_ready), .out_ch(och_b), .out_re(ore_b), .out_im(oim_b));

  int total = 0;
  int fails = 0;
  longint mcoef [NCH][TAPS];
  longint hre   [NCH][TAPS];
  longint him   [NCH][TAPS];

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Requirement arithmetic restated: half-up bias, arithmetic shift, clamp.
  function automatic longint expect_out(input longint acc, input int sh);
    longint r;
    r = (acc + (longint'(1) << (sh - 1))) >>> sh;
    if (r > 64'sd2147483647) r = 64'sd2147483647;
    if (r < -64'sd2147483648) r = -64'sd2147483648;
    return r;
  endfunction

  function automatic longint coef_of(input int ch, input int k);
    logic [31:0] v;
    if (ch == NCH - 1) return -64'sd2147483648;
    v = 32'(ch * 131 + k * 17 + 5) * 32'h9E3779B1;
    return longint'($signed(v));
  endfunction

  function automatic logic [15:0] smp(input int f, input int ch, input int part);
    logic [31:0] v;
    if (ch == NCH - 1) begin
      if (part == 0) return (f % 2 == 0) ? 16'h8000 : 16'h7FFF;
      else           return (f % 2 == 0) ? 16'h7FFF : 16'h8000;
    end
    v = 32'(f * 4099 + ch * 313 + part * 7919 + 1) * 32'd40503;
    return v[23:8];
  endfunction

  task automatic cfg_write(input int ch, input int k, input longint val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 4'(ch); cfg_tap = 6'(k); cfg_coef = 32'(val);
    @(negedge clk);
    cfg_we = 1'b0;
    mcoef[ch][k] = val;
  endtask

  task automatic do_sample(input int ch, input logic [15:0] sre, input logic [15:0] sim,
                           input int stall, input bit busy_wr, input string rtag);
    longint acc_re, acc_im, e_re, e_im, l_re, l_im;
    int cnt;
    for (int k = TAPS - 1; k > 0; k--) begin
      hre[ch][k] = hre[ch][k-1];
      him[ch][k] = him[ch][k-1];
    end
    hre[ch][0] = longint'($signed(sre));
    him[ch][0] = longint'($signed(sim));
    acc_re = 0; acc_im = 0;
    for (int k = 0; k < TAPS; k++) begin
      acc_re += mcoef[ch][k] * hre[ch][k];
      acc_im += mcoef[ch][k] * him[ch][k];
    end
    e_re = expect_out(acc_re, 31);        e_im = expect_out(acc_im, 31);
    l_re = expect_out(acc_re, LOW_SHIFT); l_im = expect_out(acc_im, LOW_SHIFT);

    @(negedge clk);
    chk(ir_a == 1'b1 && ir_b == 1'b1, "R8", "in_ready idle", longint'(ir_a), 1);
    in_valid = 1'b1; in_re = sre; in_im = sim;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    cnt = 0;
    if (busy_wr) begin
      chk(ir_a == 1'b0, "R8", "in_ready busy", longint'(ir_a), 0);
      cfg_we = 1'b1; cfg_ch = 4'(ch); cfg_tap = 6'd0; cfg_coef = 32'h12345678;
      @(negedge clk);
      cnt++;
      cfg_we = 1'b0;
    end
    while (!ov_a) begin
      @(negedge clk);
      cnt++;
    end
    chk(cnt == TAPS, "R9", "latency", cnt, TAPS);
    chk(ov_b == 1'b1, "R9", "lowshift valid", longint'(ov_b), 1);
    chk(int'(och_a) == ch, "R2", "out_ch", longint'(och_a), ch);
    chk(longint'($signed(ore_a)) == e_re, rtag, "out_re", longint'($signed(ore_a)), e_re);
    chk(longint'($signed(oim_a)) == e_im, "R6", "out_im", longint'($signed(oim_a)), e_im);
    chk(longint'($signed(ore_b)) == l_re, "R5", "lowshift re", longint'($signed(ore_b)), l_re);
    chk(longint'($signed(oim_b)) == l_im, "R5", "lowshift im", longint'($signed(oim_b)), l_im);
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk(ov_a == 1'b1 && longint'($signed(ore_a)) == e_re && int'(och_a) == ch,
          "R8", "held output", longint'($signed(ore_a)), e_re);
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    chk(ov_a == 1'b0 && ir_a == 1'b1, "R8", "return to idle", longint'(ir_a), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_ch = '0; cfg_tap = '0; cfg_coef = '0;
    in_valid = 1'b0; in_re = '0; in_im = '0; out_ready = 1'b0;
    for (int c = 0; c < NCH; c++)
      for (int k = 0; k < TAPS; k++) begin
        hre[c][k] = 0; him[c][k] = 0; mcoef[c][k] = 0;
      end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ir_a == 1'b1, "R1", "in_ready after reset", longint'(ir_a), 1);
    chk(ov_a == 1'b0 && ov_b == 1'b0, "R1", "out_valid after reset", longint'(ov_a), 0);

    // R7: idle writes load every coefficient of both instances.
    for (int c = 0; c < NCH; c++)
      for (int k = 0; k < TAPS; k++)
        cfg_write(c, k, coef_of(c, k));

    // R3/R6 sweep; frame 1 channel 5 carries an ignored busy write (R7).
    for (int f = 0; f < 4; f++)
      for (int c = 0; c < NCH; c++)
        do_sample(c, smp(f, c, 0), smp(f, c, 1), (c % 5 == 2) ? 3 : 0,
                  (f == 1 && c == 5), (f == 2 && c == 5) ? "R7" : "R3");

    // R4: single tap of 2^30 puts results exactly on the rounding ties.
    for (int c = 0; c < 2; c++)
      for (int k = 0; k < TAPS; k++)
        cfg_write(c, k, (k == 0) ? 64'sd1073741824 : 64'sd0);
    for (int c = 0; c < NCH; c++) begin
      if (c == 0)      do_sample(c, 16'sd1, -16'sd1, 0, 1'b0, "R4");
      else if (c == 1) do_sample(c, 16'sd3, -16'sd3, 0, 1'b0, "R4");
      else             do_sample(c, smp(4, c, 0), smp(4, c, 1), 0, 1'b0, "R3");
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule